// File: doc/BRIEF.md
# Referenced Placement Shifter

This block places a 16-bit operand anywhere inside a 32-bit result field in one cycle. A signed 8-bit shift code sets the direction and distance: positive values move the operand toward the MSB, negative values move it toward the LSB. A reference select decides whether code zero puts the operand in the upper half or the lower half of the field. Zeros fill the positions below the placed operand. An extension bit fills the positions above it.

The shift code can come from an exponent value, from the negated exponent value, or from an immediate. The shifted word is written into a 32-bit result register. The upper and lower halves of that register load under separate strobes. An OR mode merges the new word into the value the register already holds. With OR mode, a 32-bit quantity is shifted in two passes that use the same code. The upper word is shifted with the upper reference, and the lower word is then shifted with the lower reference and ORed in.

Top module: `ref_place_shifter`

## Requirements
- R1: The effective code is selected by `code_sel`. Value 0 selects `exp_val`, value 1 selects the two's-complement negation of `exp_val`, and values 2 and 3 select `imm_code`. The negation is computed at 9 bits, so negating -128 gives +128.
- R2: The placement is p = code + 16 when `ref_hi` is 1 and p = code when `ref_hi` is 0. Operand bit k lands at result bit p + k. Result bits below p are 0, and result bits above p + 15 hold the extension bit.
- R3: When p >= 32 the shifted word is all zeros. When p <= -16 it is all extension bits. With the upper reference this means codes +16..+127 give zeros and codes -32..-128 give all extension bits. With the lower reference, codes +32..+127 give zeros and codes -16..-128 give all extension bits.
- R4: `ext_sel` sets the extension bit: 0 takes `operand[15]`, 1 takes `carry_in`, and 2 and 3 give constant 0.
- R5: When `or_en` is 1, the value written is the shifted word bitwise ORed with the current register contents. When `or_en` is 0, the shifted word is written unchanged.
- R6: `load_hi` writes only result bits 31..16, and `load_lo` writes only bits 15..0. A half whose strobe is low keeps its value.
- R7: The register changes only on a rising clock edge with a strobe high. In the cycle of the load, `result` still shows the previous value.
- R8: An active-low `rst_n` clears `result` to zero.
- R9: A 32-bit shift is done in two loads with the same code. The first loads the upper word with the upper reference and OR off. The second loads the lower word with the lower reference, zero extension and OR on. Together they produce the 32-bit value shifted by that code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| operand | input | 16 | Word to be placed |
| exp_val | input | 8 | Signed exponent value, a code source |
| imm_code | input | 8 | Signed immediate code |
| code_sel | input | 2 | Code source select |
| ref_hi | input | 1 | 1 = upper-half reference, 0 = lower-half reference |
| ext_sel | input | 2 | Extension bit source select |
| carry_in | input | 1 | Carry flag, an extension source |
| or_en | input | 1 | Merge the shifted word with the current result |
| load_hi | input | 1 | Write strobe for bits 31..16 |
| load_lo | input | 1 | Write strobe for bits 15..0 |
| result | output | 32 | Result register |

## Verification
Every immediate code from -128 to +127 is swept under both references. The operands have different sign bits, so the sweep covers every in-range placement and both off-scale plateaus and shows whether the operand edge is off by one position. Separate runs take the code from the exponent value and from its negation. These include the -128 case, which tells a 9-bit negation apart from a wrapped one. The extension sources are tried with positive and negative operands and with the carry both high and low, so each source gives a different fill. Partial-strobe, no-strobe and OR sequences check that each half holds or merges on its own. Two-pass 32-bit shifts, one left and one right, are compared against known products.

// File: rtl/ref_place_shifter.sv
module ref_place_shifter #(
  parameter int OP_W   = 16,
  parameter int CODE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OP_W-1:0]      operand,
  input  logic [CODE_W-1:0]    exp_val,
  input  logic [CODE_W-1:0]    imm_code,
  input  logic [1:0]           code_sel,
  input  logic                 ref_hi,
  input  logic [1:0]           ext_sel,
  input  logic                 carry_in,
  input  logic                 or_en,
  input  logic                 load_hi,
  input  logic                 load_lo,
  output logic [2*OP_W-1:0]    result
);
  localparam int RES_W = 2 * OP_W;
  localparam int PL_W  = CODE_W + 3;

  logic signed [CODE_W:0] exp_s, code_s;
  logic signed [PL_W-1:0] place;
  logic                   xbit;
  logic [RES_W-1:0]       arr, merged;

  assign exp_s = {exp_val[CODE_W-1], exp_val};

  always_comb begin
    case (code_sel)
      2'd0:    code_s = exp_s;
      2'd1:    code_s = -exp_s;
      default: code_s = {imm_code[CODE_W-1], imm_code};
    endcase
  end

  assign place = PL_W'(code_s) + (ref_hi ? PL_W'(OP_W) : PL_W'(0));

  always_comb begin
    case (ext_sel)
      2'd0:    xbit = operand[OP_W-1];
      2'd1:    xbit = carry_in;
      default: xbit = 1'b0;
    endcase
  end

  always_comb begin
    for (int i = 0; i < RES_W; i++) begin
      int d;
      d = i - int'(place);
      if (d < 0)
        arr[i] = 1'b0;
      else if (d < OP_W)
        arr[i] = operand[d];
      else
        arr[i] = xbit;
    end
  end

  assign merged = or_en ? (arr | result) : arr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      result <= '0;
    else begin
      if (load_hi) result[RES_W-1:OP_W] <= merged[RES_W-1:OP_W];
      if (load_lo) result[OP_W-1:0]     <= merged[OP_W-1:0];
    end
  end

  assert_off_left_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_hi && load_lo && !or_en && place >= PL_W'(RES_W)) |=> result == '0);

  assert_off_right_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_hi && load_lo && !or_en && place <= -PL_W'(OP_W)) |=> result == {RES_W{$past(xbit)}});

  assert_or_keeps_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_hi && load_lo && or_en) |=> (result & $past(result)) == $past(result));

  assert_lo_half_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_lo |=> result[OP_W-1:0] == $past(result[OP_W-1:0]));

  assert_hi_half_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_hi |=> result[RES_W-1:OP_W] == $past(result[RES_W-1:OP_W]));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_hi && !load_lo) |=> $stable(result));

  assert_code_zero_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_hi && !or_en && code_s == 0 && ref_hi) |=> result[RES_W-1:OP_W] == $past(operand));
endmodule

// File: tb/ref_place_shifter_test.sv
`timescale 1ns/1ps
module ref_place_shifter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] operand = '0;
  logic [7:0]  exp_val = '0, imm_code = '0;
  logic [1:0]  code_sel = '0, ext_sel = '0;
  logic        ref_hi = 1'b0, carry_in = 1'b0, or_en = 1'b0;
  logic        load_hi = 1'b0, load_lo = 1'b0;
  logic [31:0] result;

  int checks = 0, fails = 0;
  logic [31:0] mdl = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ref_place_shifter uut (
    .clk(clk), .rst_n(rst_n), .operand(operand), .exp_val(exp_val),
    .imm_code(imm_code), .code_sel(code_sel), .ref_hi(ref_hi),
    .ext_sel(ext_sel), .carry_in(carry_in), .or_en(or_en),
    .load_hi(load_hi), .load_lo(load_lo), .result(result));

  function automatic logic [31:0] shape(input logic [15:0] op, input int p, input logic x);
    logic [63:0] t;
    if (p >= 32) return 32'h0;
    if (p <= -16) return {32{x}};
    t = {{48{x}}, op} << (p + 16);
    return t[47:16];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: result=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic apply(input logic [15:0] op, input logic [1:0] cs, input logic [7:0] ev,
                       input logic [7:0] im, input logic hi, input logic [1:0] xs,
                       input logic cy, input logic oe, input logic lh, input logic ll,
                       input string tag);
    int c;
    logic x;
    logic [31:0] w;
    @(negedge clk);
    operand = op; code_sel = cs; exp_val = ev; imm_code = im; ref_hi = hi;
    ext_sel = xs; carry_in = cy; or_en = oe; load_hi = lh; load_lo = ll;
    case (cs)
      2'd0: c = int'($signed(ev));
      2'd1: c = -int'($signed(ev));
      default: c = int'($signed(im));
    endcase
    x = (xs == 2'd0) ? op[15] : (xs == 2'd1) ? cy : 1'b0;
    w = shape(op, c + (hi ? 16 : 0), x);
    if (oe) w = w | mdl;
    if (lh) mdl[31:16] = w[31:16];
    if (ll) mdl[15:0]  = w[15:0];
    exp_q.push_back(mdl);
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) check(tag_q.pop_front(), result, exp_q.pop_front());
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: result=%h expected=completion", result);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 check("R8 reset", result, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    // R2 R3: full immediate sweep, both references
    for (int c = -128; c < 128; c++) begin
      apply(16'hA5C3, 2'd2, 8'h00, 8'(c), 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, "R2_R3 hi");
      apply(16'h4B1D, 2'd2, 8'h00, 8'(c), 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, "R2_R3 lo");
    end
    apply(16'hA5C3, 2'd2, 8'h00, 8'd0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, "R2 hi code0");
    apply(16'hA5C3, 2'd2, 8'h00, 8'd0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, "R2 lo code0");

    // R1: exponent and negated exponent sources
    apply(16'h8001, 2'd0, 8'hFB, 8'h7F, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, "R1 exp");
    apply(16'h8001, 2'd1, 8'hFB, 8'h80, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, "R1 neg exp");
    apply(16'h8001, 2'd1, 8'h80, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, "R1 neg -128");
    apply(16'h8001, 2'd0, 8'h80, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, "R1 exp -128");
    apply(16'h1234, 2'd3, 8'h05, 8'hF9, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, "R1 imm sel3");

    // R4: extension sources
    apply(16'h0F0F, 2'd2, 8'h00, 8'hF8, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, "R4 carry1");
    apply(16'h0F0F, 2'd2, 8'h00, 8'hF8, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, "R4 carry0");
    apply(16'hF0F0, 2'd2, 8'h00, 8'hF0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, "R4 zero");
    apply(16'hF0F0, 2'd2, 8'h00, 8'hF0, 1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, "R4 zero sel3");
    apply(16'hF0F0, 2'd2, 8'h00, 8'hF0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, "R4 msb");

    // R6 R7: partial and absent strobes
    apply(16'h1111, 2'd2, 8'h00, 8'd0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, "R6 base");
    apply(16'hBEEF, 2'd2, 8'h00, 8'hF8, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, "R6 hi only");
    apply(16'hCAFE, 2'd2, 8'h00, 8'd4, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, "R6 lo only");
    apply(16'hFFFF, 2'd2, 8'h00, 8'd0, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R7 no load");
    @(negedge clk);
    load_hi = 1'b1; load_lo = 1'b1; or_en = 1'b0; code_sel = 2'd2; imm_code = 8'd0;
    ref_hi = 1'b0; operand = 16'h5A5A;
    #1 check("R7 same cycle", result, mdl);
    mdl = {16'h0000, 16'h5A5A};
    exp_q.push_back(mdl); tag_q.push_back("R7 after edge");

    // R5: OR merge
    apply(16'h00F0, 2'd2, 8'h00, 8'd0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, "R5 base");
    apply(16'h0F00, 2'd2, 8'h00, 8'd4, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, "R5 or");
    apply(16'h0003, 2'd2, 8'h00, 8'd0, 1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, "R5 or hi");

    // R9: two-pass 32-bit shifts
    apply(16'h1234, 2'd2, 8'h00, 8'hFC, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, "R9 right pass1");
    apply(16'h8765, 2'd2, 8'h00, 8'hFC, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, "R9 right pass2");
    repeat (2) @(posedge clk);
    #3 check("R9 right", result, 32'h01234876);
    apply(16'h1234, 2'd2, 8'h00, 8'd4, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, "R9 left pass1");
    apply(16'h8765, 2'd2, 8'h00, 8'd4, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, "R9 left pass2");
    repeat (2) @(posedge clk);
    #3 check("R9 left", result, 32'h23487650);

    @(negedge clk);
    load_hi = 1'b0; load_lo = 1'b0;
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule